// File: doc/BRIEF.md
# Keyboard Controller Register Front End

This block sits between a processor's memory-mapped bus and a lower-level keyboard receiver. Software sees two byte-wide locations, each in its own 4-byte slot. The location at offset 0 is status when read and command when written. The location at offset 4 is data. The receiver hands over scancode bytes with a one-cycle valid strobe. The block keeps one byte for software, reports whether a byte is waiting and whether a byte was lost, and decodes a small command set. That set enables the keyboard, runs a timed self test, and loads the LED state from the data write that follows a set-LEDs command.

The command decoder is a three-state machine. The states are `CS_IDLE`, `CS_LED_WAIT` and `CS_TEST`. The transitions are:
- `CS_IDLE` to `CS_TEST` on command 0xAA.
- `CS_IDLE` to `CS_LED_WAIT` on command 0xED.
- `CS_IDLE` to `CS_IDLE` on 0xAE (which enables the keyboard) or on any other command.
- `CS_LED_WAIT` to `CS_IDLE` on a data write, which latches the LEDs.
- `CS_LED_WAIT` on a command write: the pending parameter is cancelled and the new byte is decoded as if from `CS_IDLE`. It goes to `CS_TEST` on 0xAA, back to `CS_LED_WAIT` on 0xED, and to `CS_IDLE` otherwise.
- `CS_TEST` to `CS_IDLE` when the cycle counter expires, which loads the pass code into the data buffer.

Top module: `kbc_regfront`

## Requirements
- R1: After reset the status byte reads 0x00, the LED outputs are 0, the keyboard is disabled and `test_pass` is 0.
- R2: A read at offset 0 returns status and a read at offset 4 returns the data buffer. Any other offset, or no read, gives 0. Status bits: bit0 byte waiting, bit1 overrun, bit2 keyboard enabled, bit3 self test busy, bit4 LED parameter pending, bits 7:5 zero.
- R3: Until command 0xAE has been written, incoming scancodes are dropped and status is unchanged. After 0xAE, status bit2 stays set.
- R4: An accepted scancode sets bit0. A data read returns that byte and clears bit0 at the end of the read cycle.
- R5: A scancode that arrives while bit0 is set is dropped and sets bit1, and the buffered byte is kept. A status read clears bit1.
- R6: After command 0xED, bit4 is set. The next data write drives `led` from wdata[2:0] and clears bit4. A data write with no parameter pending has no effect.
- R7: A command written while bit4 is set cancels the pending parameter, and that command is then decoded normally.
- R8: Command 0xAA sets bit3 and clears `test_pass`. Exactly TEST_CYCLES cycles after the write edge, bit3 clears, the data buffer holds 0x55, bit0 is set and `test_pass` is 1. Commands written while bit3 is set are ignored.
- R9: Command bytes other than 0xAA, 0xAE and 0xED change nothing.
- R10: If a scancode arrives in the same cycle as a data read of a full buffer, the read returns the old byte, the new byte is kept, bit0 stays set and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sc_valid | input | 1 | Scancode strobe from receiver |
| sc_byte | input | 8 | Scancode byte |
| led | output | LED_W | LED state |
| test_pass | output | 1 | Self test completed with pass |

## Verification
On every cycle, the assertions check these properties:
- The LED state changes only on a data write in `CS_LED_WAIT`.
- The enable is sticky.
- A full buffer keeps its byte unless it is read or reloaded.
- A disabled keyboard never changes the buffer.
- A lost byte always raises overrun.
- The self test holds off commands and ends in `CS_IDLE` with a pass.

Only the bench's scenarios can show the rest:
- The exact register contents software observes.
- The counted self-test latency.
- Cancellation followed by re-decoding of a new command.
- The same-cycle read and capture case.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    typedef enum logic [1:0] {
        CS_IDLE     = 2'd0,
        CS_LED_WAIT = 2'd1,
        CS_TEST     = 2'd2
    } cmd_state_t;

    localparam logic [7:0] CMD_SELF_TEST = 8'hAA;
    localparam logic [7:0] CMD_ENABLE    = 8'hAE;
    localparam logic [7:0] CMD_SET_LEDS  = 8'hED;
    localparam logic [7:0] TEST_OK_CODE  = 8'h55;

    localparam int SB_FULL = 0;
    localparam int SB_OVR  = 1;
    localparam int SB_EN   = 2;
    localparam int SB_BUSY = 3;
    localparam int SB_PEND = 4;
endpackage

// File: rtl/kbc_bus_if.sv
module kbc_bus_if #(
    parameter int ADDR_W   = 3,
    parameter int STAT_OFS = 0,
    parameter int DATA_OFS = 4
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        status_i,
    input  logic [7:0]        data_i,
    output logic              cmd_wr_o,
    output logic              data_wr_o,
    output logic              stat_rd_o,
    output logic              data_rd_o,
    output logic [7:0]        rdata_o
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);

    logic hit_stat, hit_data;

    always_comb begin
        hit_stat  = (bus_addr == A_STAT);
        hit_data  = (bus_addr == A_DATA);
        cmd_wr_o  = bus_sel &  bus_wr & hit_stat;
        data_wr_o = bus_sel &  bus_wr & hit_data;
        stat_rd_o = bus_sel & ~bus_wr & hit_stat;
        data_rd_o = bus_sel & ~bus_wr & hit_data;
        rdata_o   = 8'h00;
        if (stat_rd_o)      rdata_o = status_i;
        else if (data_rd_o) rdata_o = data_i;
    end
endmodule

// File: rtl/kbc_scan_buf.sv
module kbc_scan_buf
    import kbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       sc_valid_i,
    input  logic [7:0] sc_byte_i,
    input  logic       rd_i,
    input  logic       srd_i,
    input  logic       load_i,
    output logic       full_o,
    output logic       ovr_o,
    output logic [7:0] data_o
);
    logic       full_q, ovr_q;
    logic [7:0] data_q;
    logic       take, lost;

    always_comb begin
        take = sc_valid_i & en_i & (~full_q | rd_i);
        lost = sc_valid_i & en_i & full_q & ~rd_i & ~load_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            data_q <= 8'h00;
        end else begin
            if (load_i) begin
                data_q <= TEST_OK_CODE;
                full_q <= 1'b1;
            end else if (take) begin
                data_q <= sc_byte_i;
                full_q <= 1'b1;
            end else if (rd_i) begin
                full_q <= 1'b0;
            end
            if (lost)       ovr_q <= 1'b1;
            else if (srd_i) ovr_q <= 1'b0;
        end
    end

    assign full_o = full_q;
    assign ovr_o  = ovr_q;
    assign data_o = data_q;

    a_r5_keep_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !rd_i && !load_i) |=> $stable(data_q));
    a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid_i && en_i && full_q && !rd_i && !load_i) |=> (ovr_q && full_q));
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !sc_valid_i && !load_i) |=> !full_q);
    a_r3_disabled_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i) |=> $stable(data_q));
endmodule

// File: rtl/kbc_cmd_fsm.sv
module kbc_cmd_fsm
    import kbc_pkg::*;
#(
    parameter int TEST_CYCLES = 16,
    parameter int LED_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr_i,
    input  logic             data_wr_i,
    input  logic [7:0]       wdata_i,
    output logic             en_o,
    output logic [LED_W-1:0] led_o,
    output logic             busy_o,
    output logic             pend_o,
    output logic             load_o,
    output logic             pass_o
);
    localparam int CNT_W = $clog2(TEST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_START = CNT_W'(TEST_CYCLES - 1);

    cmd_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             en_q, pass_q;
    logic [LED_W-1:0] led_q;
    logic             accept_cmd;

    function automatic cmd_state_t decode(input logic [7:0] code);
        if (code == CMD_SELF_TEST)     return CS_TEST;
        else if (code == CMD_SET_LEDS) return CS_LED_WAIT;
        else                           return CS_IDLE;
    endfunction

    always_comb begin
        state_d    = state_q;
        load_o     = 1'b0;
        accept_cmd = cmd_wr_i & (state_q != CS_TEST);
        unique case (state_q)
            CS_IDLE: begin
                if (cmd_wr_i) state_d = decode(wdata_i);
            end
            CS_LED_WAIT: begin
                if (cmd_wr_i)       state_d = decode(wdata_i);
                else if (data_wr_i) state_d = CS_IDLE;
            end
            CS_TEST: begin
                if (cnt_q == '0) begin
                    state_d = CS_IDLE;
                    load_o  = 1'b1;
                end
            end
            default: state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            led_q  <= '0;
            cnt_q  <= '0;
            pass_q <= 1'b0;
        end else begin
            if (accept_cmd && wdata_i == CMD_ENABLE) en_q <= 1'b1;
            if (state_q == CS_LED_WAIT && !cmd_wr_i && data_wr_i)
                led_q <= wdata_i[LED_W-1:0];
            if (accept_cmd && wdata_i == CMD_SELF_TEST) begin
                cnt_q  <= CNT_START;
                pass_q <= 1'b0;
            end else if (state_q == CS_TEST && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (load_o) pass_q <= 1'b1;
        end
    end

    assign en_o   = en_q;
    assign led_o  = led_q;
    assign pass_o = pass_q;
    assign busy_o = (state_q == CS_TEST);
    assign pend_o = (state_q == CS_LED_WAIT);

    a_r6_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == CS_LED_WAIT && data_wr_i) |=> $stable(led_q));
    a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);
    a_r8_test_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_TEST && cnt_q == '0) |=> (state_q == CS_IDLE && pass_q));
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_TEST && cnt_q != '0) |=> (state_q == CS_TEST && !pass_q));
endmodule

// File: rtl/kbc_regfront.sv
module kbc_regfront
    import kbc_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int STAT_OFS    = 0,
    parameter int DATA_OFS    = 4,
    parameter int LED_W       = 3,
    parameter int TEST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              sc_valid,
    input  logic [7:0]        sc_byte,
    output logic [LED_W-1:0]  led,
    output logic              test_pass
);
    logic       cmd_wr, data_wr, stat_rd, data_rd;
    logic       kbd_en, busy, pend, load;
    logic       full, ovr;
    logic [7:0] data_byte, status;

    always_comb begin
        status          = 8'h00;
        status[SB_FULL] = full;
        status[SB_OVR]  = ovr;
        status[SB_EN]   = kbd_en;
        status[SB_BUSY] = busy;
        status[SB_PEND] = pend;
    end

    kbc_bus_if #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .DATA_OFS(DATA_OFS)) u_bus (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .status_i(status), .data_i(data_byte),
        .cmd_wr_o(cmd_wr), .data_wr_o(data_wr),
        .stat_rd_o(stat_rd), .data_rd_o(data_rd),
        .rdata_o(bus_rdata)
    );

    kbc_cmd_fsm #(.TEST_CYCLES(TEST_CYCLES), .LED_W(LED_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr_i(cmd_wr), .data_wr_i(data_wr), .wdata_i(bus_wdata),
        .en_o(kbd_en), .led_o(led), .busy_o(busy), .pend_o(pend),
        .load_o(load), .pass_o(test_pass)
    );

    kbc_scan_buf u_buf (
        .clk(clk), .rst_n(rst_n),
        .en_i(kbd_en), .sc_valid_i(sc_valid), .sc_byte_i(sc_byte),
        .rd_i(data_rd), .srd_i(stat_rd), .load_i(load),
        .full_o(full), .ovr_o(ovr), .data_o(data_byte)
    );

    a_r9_unknown_cmd_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !pend && !busy && bus_wdata != CMD_SELF_TEST &&
         bus_wdata != CMD_ENABLE && bus_wdata != CMD_SET_LEDS)
        |=> (!busy && !pend && $stable(kbd_en) && $stable(led)));
endmodule

// File: tb/kbc_regfront_bench.sv
`timescale 1ns/1ps
module kbc_regfront_bench;
    localparam int ST = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sc_valid = 1'b0;
    logic [7:0] sc_byte = '0;
    logic [2:0] led;
    logic       test_pass;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];
    bit         finished = 0;

    always #4 clk = ~clk;

    kbc_regfront #(.TEST_CYCLES(ST)) u_kbc_regfront (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sc_valid(sc_valid), .sc_byte(sc_byte), .led(led), .test_pass(test_pass)
    );

    function automatic logic [7:0] st(bit full, bit ovr, bit en, bit busy, bit pend);
        return {3'b000, pend, busy, en, ovr, full};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // monitor: compares every bus read against the scoreboard queue
    initial forever begin
        @(negedge clk);
        #2;
        if (bus_sel && !bus_wr) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard: unexpected read actual %02h expected none", bus_rdata);
            end else begin
                chk(req_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic rd(logic [2:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        exp_q.push_back(exp); req_q.push_back(req);
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk);
        sc_valid = 1; sc_byte = b;
        @(negedge clk);
        sc_valid = 0;
    endtask

    task automatic rd_with_sc(logic [7:0] exp, logic [7:0] b, string req);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = 3'd4;
        sc_valid = 1; sc_byte = b;
        exp_q.push_back(exp); req_q.push_back(req);
        @(negedge clk);
        bus_sel = 0; sc_valid = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 led", {5'b0, led}, 8'h00);
        chk("R1 test_pass", {7'b0, test_pass}, 8'h00);
        rd(3'd0, st(0,0,0,0,0), "R1 status");
        rd(3'd4, 8'h00, "R2 data empty");
        rd(3'd2, 8'h00, "R2 unmapped");

        // R3: disabled keyboard drops scancodes
        send(8'h1C);
        rd(3'd0, st(0,0,0,0,0), "R3 disabled drop");
        // R9: unknown command
        wr(3'd0, 8'h12);
        rd(3'd0, st(0,0,0,0,0), "R9 unknown cmd");
        wr(3'd0, 8'hAE);
        rd(3'd0, st(0,0,1,0,0), "R3 enabled");

        // R4: capture and read
        send(8'h1C);
        rd(3'd0, st(1,0,1,0,0), "R4 full");
        rd(3'd4, 8'h1C, "R4 data");
        rd(3'd0, st(0,0,1,0,0), "R4 cleared");

        // R5: overrun
        send(8'h32);
        send(8'h21);
        rd(3'd0, st(1,1,1,0,0), "R5 overrun");
        rd(3'd4, 8'h32, "R5 kept byte");
        rd(3'd0, st(0,0,1,0,0), "R5 overrun cleared");

        // R6: set LEDs
        wr(3'd0, 8'hED);
        rd(3'd0, st(0,0,1,0,1), "R6 pending");
        wr(3'd4, 8'h05);
        #1 chk("R6 led set", {5'b0, led}, 8'h05);
        rd(3'd0, st(0,0,1,0,0), "R6 pending cleared");
        wr(3'd4, 8'h02);
        #1 chk("R6 stray data write", {5'b0, led}, 8'h05);

        // R7: cancel and re-decode
        wr(3'd0, 8'hED);
        wr(3'd0, 8'h99);
        rd(3'd0, st(0,0,1,0,0), "R7 cancelled");
        wr(3'd4, 8'h03);
        #1 chk("R7 led after cancel", {5'b0, led}, 8'h05);
        wr(3'd0, 8'hED);
        wr(3'd0, 8'hED);
        rd(3'd0, st(0,0,1,0,1), "R7 re-decoded");
        wr(3'd4, 8'h07);
        #1 chk("R7 led new param", {5'b0, led}, 8'h07);

        // R10: read and capture in one cycle
        send(8'h40);
        rd_with_sc(8'h40, 8'h41, "R10 old byte");
        rd(3'd0, st(1,0,1,0,0), "R10 status");
        rd(3'd4, 8'h41, "R10 new byte");

        // R8: self test timing
        wr(3'd0, 8'hAA);
        #1 chk("R8 pass cleared", {7'b0, test_pass}, 8'h00);
        repeat (ST - 1) @(negedge clk);
        #1 chk("R8 not yet done", {7'b0, test_pass}, 8'h00);
        @(negedge clk);
        #1 chk("R8 done", {7'b0, test_pass}, 8'h01);
        rd(3'd0, st(1,0,1,0,0), "R8 status after test");
        rd(3'd4, 8'h55, "R8 pass code");

        // R8: commands ignored while busy
        wr(3'd0, 8'hAA);
        rd(3'd0, st(0,0,1,1,0), "R8 busy");
        wr(3'd0, 8'hED);
        repeat (ST + 4) @(negedge clk);
        rd(3'd0, st(1,0,1,0,0), "R8 cmd ignored");
        rd(3'd4, 8'h55, "R8 second pass code");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule